// File: doc/BRIEF.md
# Two-Wire Register Access Target

This block lets an external bus controller reach a small bank of 8-bit control registers over a two-wire serial bus (clock line and data line, I2C-compatible timing). The block never starts a transfer. It oversamples both bus lines with a faster system clock, filters short glitches, and then recognises start, stop and repeated-start conditions. It answers only to one fixed 7-bit device address. Every transaction carries one register address byte and at most one register data byte.

A write frame consists of a start, the device address with direction 0, the register address and one data byte, then a stop. Once the acknowledge clock of the data byte has ended, the block emits a one-cycle write strobe with the register address and the data. A read starts with a write frame that carries only the register address. That address sets an internal pointer. A repeated start with direction 1 follows, and the block then shifts out the byte that the register bank returns for the pointer. The data line is driven only through a pull-low enable, which gives open-drain behaviour.

Top module: `twowire_reg_target`

## Requirements
- R1: While reset is asserted and right after it is released, `sdaPullLow` and `wrStrobe` are both 0.
- R2: A start is a falling data line while the clock line is high, and a stop is a rising data line while the clock line is high. After a start, the block acknowledges the address byte 0b1000100 followed by a direction bit. Direction 0 means write and 1 means read. To acknowledge, the block holds the data line low for the whole high phase of the ninth clock.
- R3: When the received address does not match, the data line stays released during the ninth clock. The block then ignores every later byte, acknowledges none of them and writes nothing, until the next start.
- R4: In a write frame, the register address byte and the data byte are each acknowledged. After the clock falls at the end of the data byte's acknowledge, `wrStrobe` is high for exactly one system clock cycle. During that cycle `wrAddr` equals the register address byte and `wrData` equals the data byte. Each frame produces at most one strobe, and the strobe occurs only while the clock line is low.
- R5: Any byte that follows the single data byte before a stop is not acknowledged and does not cause another strobe.
- R6: A read works as follows. A frame that carries only a register address loads the pointer, and `rdAddr` presents that pointer. A repeated start with direction 1 follows and is acknowledged. The block then shifts out `rdData` MSB first. After the eighth bit it releases the data line. The output enable changes only while the clock line is low.
- R7: A repeated start, that is a start with no stop before it, restarts address matching from the first bit, whatever the previous state was.
- R8: A stop that arrives before the data byte has been acknowledged produces no write strobe.
- R9: A pulse on the clock line that lasts fewer than `FILTER_LEN` system clock cycles is ignored and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullLow | output | 1 | When 1, the pad pulls the data line low |
| wrStrobe | output | 1 | One-cycle register write strobe |
| wrAddr | output | 8 | Register address for the write |
| wrData | output | 8 | Register data for the write |
| rdAddr | output | 8 | Register pointer presented to the bank for reads |
| rdData | input | 8 | Register contents returned by the bank for `rdAddr` |

## Verification
The bench targets the following corner cases:
- A wrong device address. A design that handled it wrongly would still acknowledge it, or would write a register from the bytes that follow.
- A surplus byte after the data byte. A faulty design would acknowledge it or strobe a second time.
- A stop that arrives after only the register address. A faulty design would commit a stale data byte.
- A repeated start that follows a half-finished frame. A design that kept its old bit count or state would lose the next address.
- A short spike on the clock line in the middle of the address. A design that counted it would shift the address by one bit and refuse the acknowledge.
- Read-back of every written value. Bit-order or pointer errors would show up here as wrong bytes.
- Data-line changes while the clock line is high. The bench watches for these, because the controller would take any such change as a false start or stop.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_REG, ST_REG_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_DONE
  } twrState_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic clrBit;   // restart bit counting
    logic shiftIn;  // sample data line on a clock rise
    logic loadPtr;  // received byte becomes register pointer
    logic loadData; // received byte becomes write data
    logic loadTx;   // fetch read byte from the bank
    logic shiftTx;  // advance read byte by one bit
    logic commit;   // issue write strobe
    logic ackOe;    // hold data line low for acknowledge
    logic txEn;     // read byte owns the data line
  } twrCtl_t;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int LINES      = 2,
  parameter int FILTER_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] cleanOut
);
  localparam int FW = $clog2(FILTER_LEN + 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic s1, s2;
    logic [FW-1:0] runLen;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        runLen <= '0;
        cleanOut[g] <= 1'b1;
      end else begin
        s1 <= rawIn[g];
        s2 <= s1;
        if (s2 != cleanOut[g]) begin
          if (runLen == FW'(FILTER_LEN - 1)) begin
            cleanOut[g] <= s2;
            runLen <= '0;
          end else begin
            runLen <= runLen + 1'b1;
          end
        end else begin
          runLen <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/twr_ctrl.sv
module twr_ctrl
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic              byteFull,
  input  logic [BYTE_W-1:0] rxByte,
  output twrCtl_t           ctl
);
  logic sclQ, sdaQ, isRead, isReadNxt;
  twrState_e state, stateNxt;
  logic sclRise, sclFall, startEv, stopEv, endByte;

  assign sclRise = sclF & ~sclQ;
  assign sclFall = ~sclF & sclQ;
  assign startEv = sclF & sclQ & sdaQ & ~sdaF;
  assign stopEv  = sclF & sclQ & ~sdaQ & sdaF;
  assign endByte = sclFall & byteFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      state <= ST_IDLE;
      isRead <= 1'b0;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
      state <= stateNxt;
      isRead <= isReadNxt;
    end
  end

  always_comb begin
    ctl = '0;
    stateNxt = state;
    isReadNxt = isRead;
    if (startEv) begin
      stateNxt = ST_ADDR;
      ctl.clrBit = 1'b1;
    end else if (stopEv) begin
      stateNxt = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          ctl.shiftIn = sclRise;
          if (endByte) begin
            ctl.clrBit = 1'b1;
            if (rxByte[7:1] == DEV_ADDR) begin
              stateNxt = ST_ADDR_ACK;
              isReadNxt = rxByte[0];
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          if (isRead) begin
            stateNxt = ST_RDATA;
            ctl.loadTx = 1'b1;
          end else begin
            stateNxt = ST_REG;
          end
        end
        ST_REG: begin
          ctl.shiftIn = sclRise;
          if (endByte) begin
            stateNxt = ST_REG_ACK;
            ctl.loadPtr = 1'b1;
            ctl.clrBit = 1'b1;
          end
        end
        ST_REG_ACK: if (sclFall) stateNxt = ST_WDATA;
        ST_WDATA: begin
          ctl.shiftIn = sclRise;
          if (endByte) begin
            stateNxt = ST_WDATA_ACK;
            ctl.loadData = 1'b1;
            ctl.clrBit = 1'b1;
          end
        end
        ST_WDATA_ACK: if (sclFall) begin
          stateNxt = ST_DONE;
          ctl.commit = 1'b1;
        end
        ST_RDATA: begin
          ctl.shiftIn = sclRise;
          if (endByte) begin
            stateNxt = ST_DONE;
            ctl.clrBit = 1'b1;
          end else if (sclFall) begin
            ctl.shiftTx = 1'b1;
          end
        end
        default: ;
      endcase
    end
    ctl.ackOe = (state == ST_ADDR_ACK) || (state == ST_REG_ACK) ||
                (state == ST_WDATA_ACK);
    ctl.txEn  = (state == ST_RDATA);
  end
endmodule

// File: rtl/twr_datapath.sv
module twr_datapath
  import twr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaF,
  input  twrCtl_t           ctl,
  input  logic [BYTE_W-1:0] rdData,
  output logic              byteFull,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] regPtr,
  output logic [BYTE_W-1:0] dataReg,
  output logic              wrStrobe,
  output logic              sdaPullLow
);
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      byteFull <= 1'b0;
      rxByte <= '0;
      regPtr <= '0;
      dataReg <= '0;
      txShift <= '1;
      wrStrobe <= 1'b0;
    end else begin
      wrStrobe <= ctl.commit;
      if (ctl.clrBit) begin
        bitCnt <= '0;
        byteFull <= 1'b0;
      end else if (ctl.shiftIn) begin
        rxByte <= {rxByte[BYTE_W-2:0], sdaF};
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(BYTE_W - 1)) byteFull <= 1'b1;
      end
      if (ctl.loadPtr)  regPtr <= rxByte;
      if (ctl.loadData) dataReg <= rxByte;
      if (ctl.loadTx)       txShift <= rdData;
      else if (ctl.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign sdaPullLow = ctl.ackOe | (ctl.txEn & ~txShift[BYTE_W-1]);
endmodule

// File: rtl/twowire_reg_target.sv
module twowire_reg_target
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'b1000100,
  parameter int         FILTER_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  output logic              wrStrobe,
  output logic [BYTE_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdAddr,
  input  logic [BYTE_W-1:0] rdData
);
  logic [1:0] clean;
  logic byteFull;
  logic [BYTE_W-1:0] rxByte, regPtr;
  twrCtl_t ctl;

  twr_sync #(.LINES(2), .FILTER_LEN(FILTER_LEN)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn({sclIn, sdaIn}), .cleanOut(clean)
  );

  twr_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(clean[1]), .sdaF(clean[0]),
    .byteFull(byteFull), .rxByte(rxByte), .ctl(ctl)
  );

  twr_datapath u_dp (
    .clk(clk), .rstN(rstN), .sdaF(clean[0]), .ctl(ctl), .rdData(rdData),
    .byteFull(byteFull), .rxByte(rxByte), .regPtr(regPtr), .dataReg(wrData),
    .wrStrobe(wrStrobe), .sdaPullLow(sdaPullLow)
  );

  assign wrAddr = regPtr;
  assign rdAddr = regPtr;
endmodule

// File: rtl/twr_checker.sv
module twr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaPullLow,
  input logic       wrStrobe,
  input logic [7:0] wrData
);
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!sdaPullLow && !wrStrobe);
    end
  end

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  p_strobe_scl_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> !sclIn);

  p_strobe_data_settled_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> $stable(wrData));

  p_oe_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclIn);
endmodule

bind twowire_reg_target twr_checker u_twr_checker (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .wrStrobe(wrStrobe), .wrData(wrData)
);

// File: tb/test_twowire_reg_target.sv
module test_twowire_reg_target;
  localparam int Q = 16;
  localparam logic [6:0] DEV = 7'b1000100;
  localparam int NVEC = 6;
  // {register address, data}
  localparam logic [15:0] VECS [NVEC] = '{
    16'h00A5, 16'h033C, 16'h07FF, 16'h0F00, 16'h0981, 16'h045A
  };

  logic clk = 1'b0, rstN = 1'b0, sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaPullLow, wrStrobe, sdaLine;
  logic [7:0] wrAddr, wrData, rdAddr, rdData;
  logic [7:0] bank [16];
  int checks = 0, fails = 0, strobes = 0, oeViol = 0;
  logic [7:0] lastA, lastD;
  logic prevOe = 1'b0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaPullLow;
  assign rdData = bank[rdAddr[3:0]];

  twowire_reg_target i_twowire_reg_target (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) bank[i] <= 8'h00;
      strobes <= 0;
    end else if (wrStrobe) begin
      bank[wrAddr[3:0]] <= wrData;
      strobes <= strobes + 1;
      lastA <= wrAddr;
      lastD <= wrData;
    end
    if (rstN && sclDrv && (prevOe != sdaPullLow)) oeViol <= oeViol + 1;
    prevOe <= sdaPullLow;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic putBit(input logic b);
    sdaDrv = b; waitQ();
    sclDrv = 1'b1; waitQ(); waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b);
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  // glitchAt >= 0 inserts a short clock-line spike after that bit
  task automatic sendByte(input logic [7:0] d, input int glitchAt, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      putBit(d[i]);
      if (glitchAt == 7 - i) begin
        sclDrv = 1'b1; repeat (2) @(negedge clk);
        sclDrv = 1'b0; waitQ();
      end
    end
    getBit(a);
    ack = ~a;
  endtask

  task automatic recvByte(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      d[i] = b;
    end
    putBit(1'b1);
  endtask

  task automatic writeFrame(input logic [7:0] ra, input logic [7:0] wd, string req);
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, -1, a); check({req, " addr ack"}, a, 1);
    sendByte(ra, -1, a);          check({req, " reg ack"}, a, 1);
    sendByte(wd, -1, a);          check({req, " data ack"}, a, 1);
    busStop();
  endtask

  task automatic readFrame(input logic [7:0] ra, output logic [7:0] d);
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, -1, a); check("R6 ptr addr ack", a, 1);
    sendByte(ra, -1, a);          check("R6 ptr reg ack", a, 1);
    busStart();
    sendByte({DEV, 1'b1}, -1, a); check("R6 read addr ack", a, 1);
    check("R6 rdAddr pointer", rdAddr, ra);
    recvByte(d);
    busStop();
  endtask

  initial begin
    logic a;
    logic [7:0] rd;
    int base;
    repeat (3) @(negedge clk);
    check("R1 reset oe", sdaPullLow, 0);
    check("R1 reset strobe", wrStrobe, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset oe", sdaPullLow, 0);
    check("R1 after reset strobe", wrStrobe, 0);
    waitQ();

    // table walk: write then read back (R2, R4, R6)
    for (int i = 0; i < NVEC; i++) begin
      base = strobes;
      writeFrame(VECS[i][15:8], VECS[i][7:0], "R2 R4");
      check("R4 one strobe", strobes - base, 1);
      check("R4 wrAddr", lastA, VECS[i][15:8]);
      check("R4 wrData", lastD, VECS[i][7:0]);
    end
    for (int i = 0; i < NVEC; i++) begin
      readFrame(VECS[i][15:8], rd);
      check("R6 read byte", rd, VECS[i][7:0]);
    end

    // R3: wrong device address
    base = strobes;
    busStart();
    sendByte({7'b1000101, 1'b0}, -1, a); check("R3 mismatch nack", a, 0);
    sendByte(8'h02, -1, a);              check("R3 ignored reg byte", a, 0);
    sendByte(8'h99, -1, a);              check("R3 ignored data byte", a, 0);
    busStop();
    check("R3 no strobe", strobes - base, 0);

    // R5: surplus byte after data
    base = strobes;
    busStart();
    sendByte({DEV, 1'b0}, -1, a);
    sendByte(8'h05, -1, a);
    sendByte(8'h77, -1, a); check("R5 data ack", a, 1);
    sendByte(8'h11, -1, a); check("R5 surplus nack", a, 0);
    busStop();
    check("R5 single strobe", strobes - base, 1);
    check("R5 data kept", lastD, 8'h77);

    // R8: stop after register byte only
    base = strobes;
    busStart();
    sendByte({DEV, 1'b0}, -1, a);
    sendByte(8'h06, -1, a);
    busStop();
    check("R8 no strobe", strobes - base, 0);

    // R7: repeated starts restart matching
    base = strobes;
    busStart();
    sendByte({DEV, 1'b0}, -1, a);
    putBit(1'b1); putBit(1'b0); putBit(1'b1);
    busStart();
    sendByte({7'b0010001, 1'b0}, -1, a); check("R7 restarted mismatch nack", a, 0);
    busStart();
    sendByte({DEV, 1'b0}, -1, a); check("R7 restarted match ack", a, 1);
    sendByte(8'h08, -1, a);
    sendByte(8'hC3, -1, a);
    busStop();
    check("R7 strobe count", strobes - base, 1);
    check("R7 wrAddr", lastA, 8'h08);
    check("R7 wrData", lastD, 8'hC3);

    // R9: clock spike inside address byte
    base = strobes;
    busStart();
    sendByte({DEV, 1'b0}, 3, a); check("R9 spike ignored ack", a, 1);
    sendByte(8'h0A, -1, a);
    sendByte(8'h6E, -1, a);
    busStop();
    check("R9 strobe count", strobes - base, 1);
    check("R9 wrData", lastD, 8'h6E);
    readFrame(8'h0A, rd);
    check("R9 R6 read back", rd, 8'h6E);

    check("R6 oe stable while clock high", oeViol, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule